// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block performs one complete page read against a NAND device. It does not drive the device pins itself. Instead, it hands a sequence of byte-wide requests to a separate bus cycle generator, and that generator shapes the strobes. A read runs in this order:

- raise chip select;
- send the opening command byte;
- send the address, one latch cycle per byte;
- send a confirm command, if one is enabled;
- wait for the device's ready/busy line to report that the internal array access has finished;
- pull the programmed number of data bytes out of the device.

The user supplies the opening and confirm command codes, a confirm enable, an address of up to five bytes, the number of address cycles and the number of data bytes. A one-clock start pulse launches the read. The block captures all of these settings on that start pulse. Read bytes come out as a stream with a one-clock valid strobe. A done pulse marks the end of the operation, and the sequencer then goes back to idle.

Each request to the cycle generator stays up until the generator acknowledges it with a one-clock pulse. For read requests, the returned byte arrives with that acknowledge. The ready/busy input passes through a two-flop synchronizer. It is only sampled once a fixed settling delay has elapsed after the last command, which gives the device time to pull the line busy.

Top module: `nand_page_reader`

## Requirements
- R1: `chip_sel_o` rises only in the cycle after an accepted `start_i`. It stays high during every request issued for that operation. It is low again when `done_o` pulses.
- R2: Requests follow a fixed order: the opening command, then the address bytes, then the confirm command (only when `cmd2_en_i` was 1 at start), then the data reads. `cyc_kind_o` encodes the request type as 0 = command, 1 = address, 2 = data read.
- R3: Address bytes are sent least-significant first. Byte k is `addr_i[8k+7:8k]`. The address cycle count is taken from `addr_cycles_i`: a value of 0 is treated as 1, and values above 5 are treated as 5.
- R4: Once `cyc_req_o` is raised, it stays high with an unchanged `cyc_kind_o` and `cyc_wdata_o` until `cyc_ack_i` is sampled high.
- R5: Suppose the device is already ready. Then the first data read request appears TWB_CYC+1 clock edges after the edge on which the last command's acknowledge is accepted.
- R6: No data read request is issued until the synchronized ready/busy line shows ready (`ready_busy_i` = 1 means ready, 0 means busy). A rise of `ready_busy_i` produces the first read request on the third clock edge after it is sampled.
- R7: The byte returned with each read acknowledge appears on `data_o` with a one-cycle `data_valid_o` in the following cycle. Exactly `byte_cnt_i` bytes are read. A count of 0 issues no read requests.
- R8: `done_o` is a one-cycle pulse, one cycle after the last byte's valid. Chip select is already low at that point. The block then returns to idle and accepts a new start.
- R9: A `start_i` pulse received while an operation is in progress is ignored. Changing the inputs after start does not alter the running sequence.
- R10: After reset, `chip_sel_o`, `cyc_req_o`, `data_valid_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures all settings |
| cmd1_i | input | 8 | Opening command code |
| cmd2_i | input | 8 | Confirm command code |
| cmd2_en_i | input | 1 | Send the confirm command |
| addr_i | input | 8*ADDR_MAX | Address, byte 0 sent first |
| addr_cycles_i | input | clog2(ADDR_MAX+1) | Number of address cycles |
| byte_cnt_i | input | CNT_W | Number of data bytes to read |
| ready_busy_i | input | 1 | Device ready (1) / busy (0), asynchronous |
| chip_sel_o | output | 1 | Chip select, active high |
| cyc_req_o | output | 1 | Request to the bus cycle generator |
| cyc_kind_o | output | 2 | Request type: 0 command, 1 address, 2 read |
| cyc_wdata_o | output | 8 | Command or address byte |
| cyc_ack_i | input | 1 | Cycle complete, one-clock pulse |
| cyc_rdata_i | input | 8 | Byte read, valid with acknowledge |
| data_o | output | 8 | Read byte |
| data_valid_o | output | 1 | Read byte valid, one clock |
| done_o | output | 1 | Operation finished, one clock |

## Verification
The bound checker checks, on every cycle, the properties that are local in time:

- every request is made under chip select;
- a request holds its type and byte until it is acknowledged;
- chip select is raised only in response to start;
- read requests appear only after the synchronized line reports ready;
- a valid byte always follows a read acknowledge;
- done is a single pulse with chip select low.

Some behaviour can only be shown by the bench's directed scenarios:

- the whole request order;
- address byte order and the clamping of the cycle count;
- the exact settling delay and synchronizer latency;
- the byte count, including zero;
- that a second start mid-operation leaves no trace.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_READ = 2'd2
  } cyc_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD1,
    ST_ADDR,
    ST_CMD2,
    ST_TWB,
    ST_WAIT,
    ST_READ,
    ST_LAST,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  // reset value 0 = busy, so nothing is read before a real sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/nand_twb_timer.sv
module nand_twb_timer #(
  parameter int TWB_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int TW = $clog2(TWB_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= TW'(TWB_CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int ADDR_MAX = 5,
  parameter int CNT_W    = 16,
  parameter int TWB_CYC  = 4,
  localparam int AW      = 8 * ADDR_MAX,
  localparam int NCYC_W  = $clog2(ADDR_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        cmd1_i,
  input  logic [7:0]        cmd2_i,
  input  logic              cmd2_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NCYC_W-1:0] addr_cycles_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              ready_busy_i,
  output logic              chip_sel_o,
  output logic              cyc_req_o,
  output logic [1:0]        cyc_kind_o,
  output logic [7:0]        cyc_wdata_o,
  input  logic              cyc_ack_i,
  input  logic [7:0]        cyc_rdata_i,
  output logic [7:0]        data_o,
  output logic              data_valid_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic [7:0]        cmd1_q, cmd2_q;
  logic              cmd2_en_q;
  logic [NCYC_W-1:0] last_idx_q, last_idx_d, idx_q;
  logic [CNT_W-1:0]  left_q;
  logic [7:0]        data_q;
  logic              vld_q;
  logic              rb_ready;
  logic              twb_load, twb_exp;
  logic              addr_last;

  nand_rb_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ready_busy_i),
    .sync_o (rb_ready)
  );

  nand_twb_timer #(.TWB_CYC(TWB_CYC)) u_twb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (twb_load),
    .expire_o(twb_exp)
  );

  // clamp requested address cycles to 1..ADDR_MAX, stored as last index
  always_comb begin
    if (addr_cycles_i == '0)                         last_idx_d = '0;
    else if (addr_cycles_i > NCYC_W'(ADDR_MAX))      last_idx_d = NCYC_W'(ADDR_MAX - 1);
    else                                             last_idx_d = addr_cycles_i - 1'b1;
  end

  assign addr_last = (idx_q == last_idx_q);
  assign twb_load  = cyc_ack_i && ((state_q == ST_CMD2) ||
                     (state_q == ST_ADDR && addr_last && !cmd2_en_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      cmd1_q     <= '0;
      cmd2_q     <= '0;
      cmd2_en_q  <= 1'b0;
      last_idx_q <= '0;
      idx_q      <= '0;
      left_q     <= '0;
      data_q     <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q     <= addr_i;
          cmd1_q     <= cmd1_i;
          cmd2_q     <= cmd2_i;
          cmd2_en_q  <= cmd2_en_i;
          last_idx_q <= last_idx_d;
          left_q     <= byte_cnt_i;
          state_q    <= ST_CMD1;
        end
        ST_CMD1: if (cyc_ack_i) begin
          idx_q   <= '0;
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (cyc_ack_i) begin
          if (addr_last) state_q <= cmd2_en_q ? ST_CMD2 : ST_TWB;
          else           idx_q   <= idx_q + 1'b1;
        end
        ST_CMD2: if (cyc_ack_i) state_q <= ST_TWB;
        ST_TWB:  if (twb_exp)   state_q <= ST_WAIT;
        ST_WAIT: if (rb_ready)  state_q <= (left_q == '0) ? ST_DONE : ST_READ;
        ST_READ: if (cyc_ack_i) begin
          data_q <= cyc_rdata_i;
          vld_q  <= 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) state_q <= ST_LAST;
        end
        ST_LAST: state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cyc_req_o   = 1'b0;
    cyc_kind_o  = CYC_CMD;
    cyc_wdata_o = '0;
    unique case (state_q)
      ST_CMD1: begin cyc_req_o = 1'b1; cyc_wdata_o = cmd1_q; end
      ST_ADDR: begin
        cyc_req_o   = 1'b1;
        cyc_kind_o  = CYC_ADDR;
        cyc_wdata_o = addr_q[{idx_q, 3'b000} +: 8];
      end
      ST_CMD2: begin cyc_req_o = 1'b1; cyc_wdata_o = cmd2_q; end
      ST_READ: begin cyc_req_o = 1'b1; cyc_kind_o = CYC_READ; end
      default: ;
    endcase
  end

  assign chip_sel_o   = (state_q != ST_IDLE) && (state_q != ST_LAST) && (state_q != ST_DONE);
  assign data_o       = data_q;
  assign data_valid_o = vld_q;
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       chip_sel_o,
  input logic       cyc_req_o,
  input logic [1:0] cyc_kind_o,
  input logic [7:0] cyc_wdata_o,
  input logic       cyc_ack_i,
  input logic       data_valid_o,
  input logic       done_o,
  input logic       rb_ready
);
  assert_cs_on_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o |-> chip_sel_o);

  assert_cs_needs_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_sel_o) |-> $past(start_i));

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_req_o && !cyc_ack_i) |=> (cyc_req_o && $stable(cyc_kind_o) && $stable(cyc_wdata_o)));

  assert_read_after_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_req_o && cyc_kind_o == 2'd2) |-> rb_ready);

  assert_valid_after_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(cyc_req_o && cyc_ack_i && cyc_kind_o == 2'd2));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_cs_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !chip_sel_o);
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .chip_sel_o  (chip_sel_o),
  .cyc_req_o   (cyc_req_o),
  .cyc_kind_o  (cyc_kind_o),
  .cyc_wdata_o (cyc_wdata_o),
  .cyc_ack_i   (cyc_ack_i),
  .data_valid_o(data_valid_o),
  .done_o      (done_o),
  .rb_ready    (rb_ready)
);

// File: tb/sim_nand_page_reader.sv
`timescale 1ns/1ps
module sim_nand_page_reader;
  localparam int TWB = 4;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd1 = '0, cmd2 = '0;
  logic        cmd2_en = 1'b0;
  logic [39:0] addr = '0;
  logic [2:0]  ncyc = '0;
  logic [15:0] nbytes = '0;
  logic        rb = 1'b1;
  logic        cs, req, vld, done;
  logic [1:0]  kind;
  logic [7:0]  wdata, dout;
  logic        ack = 1'b0;
  logic [7:0]  rdata = '0;

  int nchk = 0, nfail = 0, cyc = 0;

  nand_page_reader #(.ADDR_MAX(5), .CNT_W(16), .TWB_CYC(TWB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd1_i(cmd1), .cmd2_i(cmd2),
    .cmd2_en_i(cmd2_en), .addr_i(addr), .addr_cycles_i(ncyc), .byte_cnt_i(nbytes),
    .ready_busy_i(rb), .chip_sel_o(cs), .cyc_req_o(req), .cyc_kind_o(kind),
    .cyc_wdata_o(wdata), .cyc_ack_i(ack), .cyc_rdata_i(rdata), .data_o(dout),
    .data_valid_o(vld), .done_o(done));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // cycle generator model and log
  logic [1:0] lk [0:63];
  logic [7:0] lw [0:63];
  bit         lcs[0:63];
  int         lfs[0:63], lac[0:63];
  int         ln = 0, wcnt = 0, first = 0, rd_idx = 0;
  logic [7:0] cap[0:63];
  int         ncap = 0, vcyc = 0, ndone = 0, dcyc = 0;
  bit         done_cs = 1'b0;
  bit         rb_rel = 1'b1;
  int         early_rd = 0;

  function automatic logic [7:0] pat(int i);
    return 8'hC3 + 8'(i * 7);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; wcnt = 0;
    end else if (ack) begin
      ack = 1'b0; wcnt = 0;
    end else if (req) begin
      if (wcnt == 0) first = cyc;
      if (wcnt == LAT) begin
        ack = 1'b1;
        if (ln < 64) begin
          lk[ln] = kind; lw[ln] = wdata; lcs[ln] = cs; lfs[ln] = first; lac[ln] = cyc;
        end
        ln++;
        if (kind == 2'd2) begin
          if (!rb_rel) early_rd++;
          rdata = pat(rd_idx); rd_idx++;
        end
      end else wcnt++;
    end
    if (rst_n && vld) begin
      if (ncap < 64) cap[ncap] = dout;
      ncap++; vcyc = cyc;
    end
    if (rst_n && done) begin
      ndone++; dcyc = cyc; done_cs = cs;
    end
  end

  task automatic chk(bit ok, string r, int act, int exp, string what);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic launch(logic [7:0] c1, logic [7:0] c2, bit en, logic [39:0] a,
                        logic [2:0] n, logic [15:0] b);
    @(negedge clk);
    ln = 0; ncap = 0; ndone = 0; rd_idx = 0; early_rd = 0;
    cmd1 = c1; cmd2 = c2; cmd2_en = en; addr = a; ncyc = n; nbytes = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (ndone == 0 && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  // checks order, address bytes, chip select and byte stream
  task automatic verify(logic [7:0] c1, logic [7:0] c2, bit en, logic [39:0] a,
                        int na, int nb);
    int k = 0, bad = 0, badcs = 0, badb = 0;
    if (lk[k] != 2'd0 || lw[k] != c1) bad++;
    k++;
    for (int i = 0; i < na; i++) begin
      if (lk[k] != 2'd1 || lw[k] != a[8*i +: 8]) bad++;
      k++;
    end
    if (en) begin
      if (lk[k] != 2'd0 || lw[k] != c2) bad++;
      k++;
    end
    for (int i = 0; i < nb; i++) begin
      if (lk[k] != 2'd2) bad++;
      k++;
    end
    chk(ln == k, "R2", ln, k, "request count");
    chk(bad == 0, "R2 R3", bad, 0, "sequence/address mismatches");
    for (int i = 0; i < ln && i < 64; i++) if (!lcs[i]) badcs++;
    chk(badcs == 0, "R1", badcs, 0, "requests without chip select");
    chk(ncap == nb, "R7", ncap, nb, "bytes streamed");
    for (int i = 0; i < nb && i < 64; i++) if (cap[i] != pat(i)) badb++;
    chk(badb == 0, "R7", badb, 0, "byte mismatches");
    chk(ndone == 1, "R8", ndone, 1, "done pulses");
    chk(done_cs == 1'b0, "R8", int'(done_cs), 0, "chip select at done");
    if (nb > 0) chk(dcyc == vcyc + 1, "R8", dcyc - vcyc, 1, "done after last byte");
    chk(cs == 1'b0, "R8", int'(cs), 0, "idle after done");
  endtask

  task automatic t_reset();
    chk({cs, req, vld, done} == 4'b0, "R10", int'({cs, req, vld, done}), 0, "outputs after reset");
  endtask

  task automatic t_basic();
    int lr;
    rb = 1'b1; rb_rel = 1'b1;
    launch(8'h00, 8'h30, 1'b1, 40'h00_0001_A2B3, 3'd3, 16'd4);
    wait_done();
    verify(8'h00, 8'h30, 1'b1, 40'h00_0001_A2B3, 3, 4);
    lr = 4; // cmd1 + 3 addr + cmd2 precede the first read at index 5
    chk(lfs[5] - lac[lr] == TWB + 2, "R5", lfs[5] - lac[lr], TWB + 2, "settling delay");
  endtask

  task automatic t_no_cmd2();
    rb = 1'b1; rb_rel = 1'b1;
    launch(8'h05, 8'hE0, 1'b0, 40'h00_0000_7F11, 3'd1, 16'd2);
    wait_done();
    verify(8'h05, 8'hE0, 1'b0, 40'h00_0000_7F11, 1, 2);
    chk(lfs[2] - lac[1] == TWB + 2, "R5", lfs[2] - lac[1], TWB + 2, "delay after address");
  endtask

  task automatic t_clamp();
    rb = 1'b1;
    launch(8'h00, 8'h30, 1'b1, 40'h55_4433_2211, 3'd0, 16'd1);
    wait_done();
    verify(8'h00, 8'h30, 1'b1, 40'h55_4433_2211, 1, 1);   // R3 zero -> one
    launch(8'h00, 8'h30, 1'b1, 40'h55_4433_2211, 3'd7, 16'd1);
    wait_done();
    verify(8'h00, 8'h30, 1'b1, 40'h55_4433_2211, 5, 1);   // R3 over -> five
  endtask

  task automatic t_busy();
    int rel;
    rb = 1'b0; rb_rel = 1'b0;
    launch(8'h00, 8'h30, 1'b1, 40'h00_0000_0102, 3'd2, 16'd3);
    repeat (40) @(negedge clk);
    rb = 1'b1; rb_rel = 1'b1; rel = cyc;
    wait_done();
    chk(early_rd == 0, "R6", early_rd, 0, "reads while busy");
    chk(lfs[4] - rel == 3, "R6", lfs[4] - rel, 3, "ready to first read");
    verify(8'h00, 8'h30, 1'b1, 40'h00_0000_0102, 2, 3);
  endtask

  task automatic t_zero_bytes();
    rb = 1'b1;
    launch(8'h00, 8'h30, 1'b1, 40'h00_0000_00AA, 3'd1, 16'd0);
    wait_done();
    verify(8'h00, 8'h30, 1'b1, 40'h00_0000_00AA, 1, 0);   // R7 no reads
  endtask

  task automatic t_start_ignored();
    int nl;
    rb = 1'b1;
    launch(8'h00, 8'h30, 1'b1, 40'h00_0000_C0DE, 3'd2, 16'd3);
    repeat (3) @(negedge clk);
    cmd1 = 8'hFF; cmd2 = 8'h11; addr = 40'hFF_FFFF_FFFF; ncyc = 3'd5; nbytes = 16'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    verify(8'h00, 8'h30, 1'b1, 40'h00_0000_C0DE, 2, 3);   // R9
    nl = ln;
    repeat (20) @(negedge clk);
    chk(ln == nl && cs == 1'b0, "R9", ln, nl, "no second operation");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_cmd2();
    t_clamp();
    t_busy();
    t_zero_bytes();
    t_start_ignored();
    t_basic();
    finish_run();
  end
endmodule